// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block sits next to one UART channel and runs the RTS/CTS handshake in both directions. On the receive side it compares the receive FIFO fill count with a programmable trigger level. When automatic RTS is on, it drives the active-low RTS output with hysteresis: RTS is withdrawn at a threshold above the trigger level and asserted again only after the count drops below a threshold beneath it. It also raises a level-sensitive receive-threshold interrupt.

On the transmit side it synchronises the active-low CTS input. When automatic CTS is on, it updates a transmit-allowed flag only at character boundaries, so a character that has started always finishes. The FIFOs, shift registers and baud generator are outside this block. The transmitter supplies a boundary strobe and reads the transmit-allowed flag.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After a synchronous reset, rts_n is 1, rx_thr_irq is 0 and tx_allowed is 1.
- R2: While auto_rts_en is 0, rts_n equals the inverse of rts_manual one clock later (rts_manual=1 gives rts_n=0), whatever the fill count.
- R3: The upper threshold is trig_level+hyst, clamped to DEPTH (64 by default). The lower threshold is trig_level-hyst, clamped to 0.
- R4: With auto_rts_en=1 and rts_manual=1, a fill count at or above the upper threshold sets rts_n to 1 on the next clock.
- R5: Once withdrawn by the automatic logic, RTS stays high for counts between the thresholds. It returns low on the next clock after the count falls below the lower threshold, or after the count reaches 0. If both conditions hold at once, withdrawal wins.
- R6: While rts_manual is 0, rts_n is 1 whether or not automatic RTS is enabled.
- R7: rx_thr_irq is 1 one clock after the fill count is at or above trig_level while auto_rts_en=1. It goes back to 0 once the count is below trig_level or auto_rts_en is 0.
- R8: cts_n passes through two synchroniser flops. With auto_cts_en=1, tx_allowed takes the inverse of the synchronised CTS only on a clock where tx_char_boundary is 1 and otherwise holds. A change of cts_n appears on tx_allowed at the third rising edge.
- R9: While auto_cts_en is 0, tx_allowed is 1 whatever cts_n does.
- R10: When trig_level+hyst exceeds DEPTH, RTS is withdrawn only at a fill count equal to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_rts_en | input | 1 | Enables automatic RTS and the threshold interrupt |
| auto_cts_en | input | 1 | Enables automatic CTS gating |
| rts_manual | input | 1 | Software RTS request, 1 = assert RTS |
| fill_count | input | CW | Receive FIFO fill count, 0..DEPTH |
| trig_level | input | CW | Receive trigger level |
| hyst | input | CW | Hysteresis half-band |
| cts_n | input | 1 | Active-low clear-to-send from the line |
| tx_char_boundary | input | 1 | Transmitter is between characters |
| rts_n | output | 1 | Active-low request-to-send, registered |
| tx_allowed | output | 1 | Transmitter may start a new character |
| rx_thr_irq | output | 1 | Receive-threshold interrupt, level |

## Verification
On every cycle, the assertions check the cycle-level rules. These are the manual mirror and the forced-high RTS when software has not asserted it, withdrawal at the upper threshold, release at an empty FIFO, a silent interrupt while disabled, a constant transmit flag while gating is off, and the flag holding between character boundaries. Only the bench's scenarios show the hysteresis memory, where RTS stays high while the count passes back down through the band. They also show the clamping of both thresholds at the FIFO limits and the exact three-edge latency of the CTS path.

// File: rtl/uart_fc_pkg.sv
`timescale 1ns/1ps
package uart_fc_pkg;
  typedef enum logic {
    FLOW_GO   = 1'b0,
    FLOW_HALT = 1'b1
  } flow_state_e;
endpackage

// File: rtl/fc_thresh.sv
`timescale 1ns/1ps
module fc_thresh #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] trig_level,
  input  logic [CW-1:0] hyst,
  output logic [CW-1:0] upper,
  output logic [CW-1:0] lower
);
  localparam int EW = CW + 1;
  localparam logic [EW-1:0] DEPTH_E = EW'(DEPTH);

  logic [EW-1:0] sum;
  always_comb begin
    sum = {1'b0, trig_level} + {1'b0, hyst};
    if (sum > DEPTH_E) upper = CW'(DEPTH);
    else               upper = sum[CW-1:0];
    if (hyst > trig_level) lower = '0;
    else                   lower = trig_level - hyst;
  end

  always_comb begin
    assert (upper >= lower || trig_level > CW'(DEPTH)) else $error("AST_BAND_ORDER"); // R3
  end
endmodule

// File: rtl/fc_rts_ctrl.sv
`timescale 1ns/1ps
module fc_rts_ctrl
  import uart_fc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_rts_en,
  input  logic          rts_manual,
  input  logic [CW-1:0] fill_count,
  input  logic [CW-1:0] trig_level,
  input  logic [CW-1:0] upper,
  input  logic [CW-1:0] lower,
  output logic          rts_n,
  output logic          rx_thr_irq
);
  flow_state_e state_q, state_d;
  logic        halt_hit, go_hit;

  always_comb begin
    halt_hit = fill_count >= upper;
    go_hit   = (fill_count < lower) || (fill_count == '0);
    state_d  = state_q;
    if (!auto_rts_en || !rts_manual) state_d = FLOW_GO;
    else if (halt_hit)               state_d = FLOW_HALT;
    else if (go_hit)                 state_d = FLOW_GO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FLOW_GO;
      rts_n      <= 1'b1;
      rx_thr_irq <= 1'b0;
    end else begin
      state_q    <= state_d;
      rts_n      <= !rts_manual || (state_d == FLOW_HALT);
      rx_thr_irq <= auto_rts_en && (fill_count >= trig_level);
    end
  end

  AST_RTS_MIRROR: assert property (@(posedge clk) disable iff (rst)
    !auto_rts_en |=> (rts_n == !$past(rts_manual))); // R2
  AST_NO_MANUAL_HIGH: assert property (@(posedge clk) disable iff (rst)
    !rts_manual |=> rts_n); // R6
  AST_HALT_AT_UPPER: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && rts_manual && fill_count >= upper) |=> rts_n); // R4
  AST_GO_AT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && rts_manual && fill_count == '0 && upper != '0) |=> !rts_n); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !auto_rts_en |=> !rx_thr_irq); // R7
endmodule

// File: rtl/fc_cts_gate.sv
`timescale 1ns/1ps
module fc_cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_cts_en,
  input  logic cts_n,
  input  logic tx_char_boundary,
  output logic tx_allowed
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= cts_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                   tx_allowed <= 1'b1;
    else if (!auto_cts_en)     tx_allowed <= 1'b1;
    else if (tx_char_boundary) tx_allowed <= !sync_q[SYNC_STAGES-1];
  end

  AST_CTS_OFF_OPEN: assert property (@(posedge clk) disable iff (rst)
    !auto_cts_en |=> tx_allowed); // R9
  AST_HOLD_MID_CHAR: assert property (@(posedge clk) disable iff (rst)
    (auto_cts_en && !tx_char_boundary) |=> $stable(tx_allowed)); // R8
endmodule

// File: rtl/uart_flow_ctrl.sv
`timescale 1ns/1ps
module uart_flow_ctrl #(
  parameter int DEPTH       = 64,
  parameter int CW          = $clog2(DEPTH + 1),
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic          rts_manual,
  input  logic [CW-1:0] fill_count,
  input  logic [CW-1:0] trig_level,
  input  logic [CW-1:0] hyst,
  input  logic          cts_n,
  input  logic          tx_char_boundary,
  output logic          rts_n,
  output logic          tx_allowed,
  output logic          rx_thr_irq
);
  logic [CW-1:0] upper, lower;

  fc_thresh #(.DEPTH(DEPTH), .CW(CW)) u_thresh (
    .trig_level (trig_level),
    .hyst       (hyst),
    .upper      (upper),
    .lower      (lower)
  );

  fc_rts_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_rts (
    .clk         (clk),
    .rst         (rst),
    .auto_rts_en (auto_rts_en),
    .rts_manual  (rts_manual),
    .fill_count  (fill_count),
    .trig_level  (trig_level),
    .upper       (upper),
    .lower       (lower),
    .rts_n       (rts_n),
    .rx_thr_irq  (rx_thr_irq)
  );

  fc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk              (clk),
    .rst              (rst),
    .auto_cts_en      (auto_cts_en),
    .cts_n            (cts_n),
    .tx_char_boundary (tx_char_boundary),
    .tx_allowed       (tx_allowed)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (rts_n && !rx_thr_irq && tx_allowed)); // R1
endmodule

// File: tb/tb_uart_flow_ctrl.sv
`timescale 1ns/1ps
module tb_uart_flow_ctrl;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_rts_en = 0, auto_cts_en = 0, rts_manual = 0;
  logic [CW-1:0] fill_count = '0, trig_level = '0, hyst = '0;
  logic cts_n = 1'b1, tx_char_boundary = 1'b0;
  logic rts_n, tx_allowed, rx_thr_irq;

  always #2.5 clk = ~clk;

  uart_flow_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .rts_manual(rts_manual), .fill_count(fill_count), .trig_level(trig_level),
    .hyst(hyst), .cts_n(cts_n), .tx_char_boundary(tx_char_boundary),
    .rts_n(rts_n), .tx_allowed(tx_allowed), .rx_thr_irq(rx_thr_irq)
  );

  typedef struct {
    string req;
    int    sel;   // 0 rts_n, 1 rx_thr_irq, 2 tx_allowed
    logic  val;
  } exp_t;

  exp_t exp_q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic expect_out(input string req, input int sel, input logic val);
    exp_t e;
    e.req = req; e.sel = sel; e.val = val;
    exp_q.push_back(e);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fill(input int c);
    fill_count = CW'(c);
    settle(2);
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic act;
        e = exp_q.pop_front();
        act = (e.sel == 0) ? rts_n : (e.sel == 1) ? rx_thr_irq : tx_allowed;
        compared++;
        if (act !== e.val) begin
          mismatched++;
          $display("FAIL %s sel=%0d actual=%b expected=%b", e.req, e.sel, act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst = 1'b0;
    // R1 reset state (inputs idle, sampled right after reset release)
    expect_out("R1", 0, 1'b1); expect_out("R1", 1, 1'b0); expect_out("R1", 2, 1'b1);
    settle(1);

    // R2 manual mirror with automatic RTS off, even at full FIFO
    trig_level = 7'd32; hyst = 7'd8;
    rts_manual = 1; fill_count = 7'd64; settle(2);
    expect_out("R2", 0, 1'b0); expect_out("R7", 1, 1'b0);
    settle(1);
    rts_manual = 0; settle(2);
    expect_out("R2", 0, 1'b1);
    settle(1);

    // R3/R4/R5/R7 hysteresis: upper 40, lower 24
    auto_rts_en = 1; rts_manual = 1;
    fill(31); expect_out("R7", 1, 1'b0); expect_out("R4", 0, 1'b0);
    fill(32); expect_out("R7", 1, 1'b1); expect_out("R4", 0, 1'b0);
    fill(39); expect_out("R3", 0, 1'b0);
    fill(40); expect_out("R4", 0, 1'b1);
    fill(30); expect_out("R5", 0, 1'b1); expect_out("R7", 1, 1'b0);
    fill(24); expect_out("R5", 0, 1'b1);
    fill(23); expect_out("R5", 0, 1'b0);
    settle(1);

    // R6 software not asserting RTS: stays high at empty FIFO
    rts_manual = 0; fill(0); expect_out("R6", 0, 1'b1);
    fill(50); expect_out("R6", 0, 1'b1); expect_out("R7", 1, 1'b1);
    settle(1);
    auto_rts_en = 0; settle(2); expect_out("R7", 1, 1'b0);
    settle(1);

    // R10 upper clamp: trig 60 hyst 10 -> upper 64, lower 50
    auto_rts_en = 1; rts_manual = 1; trig_level = 7'd60; hyst = 7'd10;
    fill(63); expect_out("R10", 0, 1'b0);
    fill(64); expect_out("R10", 0, 1'b1);
    fill(50); expect_out("R3", 0, 1'b1);
    fill(49); expect_out("R3", 0, 1'b0);
    settle(1);

    // R3/R5 lower clamp: trig 4 hyst 8 -> upper 12, lower 0
    trig_level = 7'd4; hyst = 7'd8;
    fill(12); expect_out("R3", 0, 1'b1);
    fill(1);  expect_out("R5", 0, 1'b1);
    fill(0);  expect_out("R5", 0, 1'b0);
    settle(1);

    // R9 gating off: CTS inactive has no effect
    cts_n = 1; tx_char_boundary = 1; settle(5);
    expect_out("R9", 2, 1'b1);
    settle(1);

    // R8 mid-character hold, then boundary update
    auto_cts_en = 1; tx_char_boundary = 0; settle(5);
    expect_out("R8", 2, 1'b1);
    settle(1);
    tx_char_boundary = 1; settle(1);
    expect_out("R8", 2, 1'b0);
    settle(1);
    tx_char_boundary = 0; cts_n = 0; settle(5);
    expect_out("R8", 2, 1'b0);
    settle(1);
    tx_char_boundary = 1; settle(1);
    expect_out("R8", 2, 1'b1);
    settle(1);

    // R8 synchroniser latency: third rising edge
    cts_n = 1; settle(2);
    expect_out("R8", 2, 1'b1);
    settle(1);
    expect_out("R8", 2, 1'b0);
    settle(1);

    // R9 disabling gating reopens immediately
    auto_cts_en = 0; settle(1);
    expect_out("R9", 2, 1'b1);
    settle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule